// File: doc/BRIEF.md
# Real-Time Clock Timebase Divider and Periodic Rate Generator

This block sits between a 32768 Hz timebase enable and the calendar core of a real-time clock. A 15-bit prescaler counts timebase ticks. Once per second it issues a one-cycle strobe that tells the calendar core to advance. During the last eight ticks before that strobe it raises an update-in-progress indication, so that software knows not to read the calendar. The same prescaler feeds a periodic event generator. A four-bit rate code selects which power-of-two tap of the count sets a sticky periodic flag. The host clears that flag when it reads the interrupt status.

A seven-bit control word is written through a simple write port. The upper three bits select the prescaler mode: run, held at the half-second point, or frozen. The lower four bits select the periodic rate. After a reset, or after the hold code is removed, the prescaler restarts at its midpoint. The first strobe therefore arrives half a second (16384 ticks) later.

Top module: `rtc_timebase`

## Requirements
- R1: After reset the control word is mode 010 (run) with rate 0110, all three outputs are low, and the first `sec_strobe` appears after the 16384th advancing tick.
- R2: In run mode `sec_strobe` pulses for exactly one clock every 32768 advancing ticks. It appears in the clock after the tick that wraps the count from 32767 to 0. Ticks only advance the count while the mode field (bits 6:4) is 010.
- R3: While the mode field is 111, the prescaler is held at count 16384, with no strobe and no update indication. After the field returns to 010, the first strobe follows the 16384th advancing tick.
- R4: Any mode code other than 010 and 111 freezes the count at its present value, including its `uip` level. The count resumes from there when 010 is written again.
- R5: `uip` is high exactly while the count is in 32760..32767, that is, from eight ticks (about 244 us) before each strobe until the strobe appears.
- R6: Rate code 0000 (bits 3:0) never sets the periodic flag.
- R7: A rate code r from 3 to 15 sets the flag on each advancing tick that leaves the low r-1 count bits all zero. This gives one event per 2^(r-1) ticks: 8192 Hz at 3, down to 2 Hz at 15.
- R8: Rate codes 0001 and 0010 behave exactly like 1000 (128 ticks) and 1001 (256 ticks).
- R9: The reset rate 0110 yields one periodic event per 32 ticks (1024 Hz).
- R10: `pf_flag` stays set until `flag_clr` is pulsed. If a periodic event and `flag_clr` occur in the same clock, the flag stays set.
- R11: A control write takes effect from the next clock. The tick in the write cycle is handled under the old mode and rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | One-cycle enable at the 32768 Hz timebase rate |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 7 | Control word: bits 6:4 mode, bits 3:0 rate |
| flag_clr | input | 1 | Clears the periodic flag (host read of interrupt status) |
| sec_strobe | output | 1 | One-clock pulse once per second |
| uip | output | 1 | Update-in-progress window before each strobe |
| pf_flag | output | 1 | Sticky periodic event flag |

## Verification
The prescaler count is visible at the ports in two ways: through `uip` within the same second, and through the spacing of `sec_strobe`. A count that is off by even one tick shifts the `uip` rise and the strobe by one clock. With fast rate codes and the flag cleared every clock, `pf_flag` traces the low count bits directly. A wrong rate decode or misaligned tap therefore shows up within one period of the selected rate, at most 16384 ticks. A wrong hold or freeze behaviour appears as a strobe at the wrong distance after the mode field returns to run.

// File: rtl/rtc_timebase_pkg.sv
package rtc_timebase_pkg;

    localparam int MODE_W = 3;
    localparam int RATE_W = 4;
    localparam int CTL_W  = MODE_W + RATE_W;

    localparam logic [MODE_W-1:0] MODE_RUN  = 3'b010;
    localparam logic [MODE_W-1:0] MODE_HOLD = 3'b111;

    localparam logic [RATE_W-1:0] RATE_RESET = 4'b0110;
    localparam logic [RATE_W-1:0] RATE_OFF   = 4'b0000;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [RATE_W-1:0] rate;
    } ctl_t;

    // Low codes 1 and 2 alias onto 8 and 9.
    function automatic logic [RATE_W-1:0] rate_effective(input logic [RATE_W-1:0] code);
        case (code)
            4'd1:    return 4'd8;
            4'd2:    return 4'd9;
            default: return code;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_timebase_pkg::*;
#(
    parameter int CNT_W     = 15,
    parameter int UIP_TICKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [MODE_W-1:0] mode,
    output logic              adv,
    output logic [CNT_W-1:0]  cnt_next,
    output logic [CNT_W-1:0]  cnt_cur,
    output logic              sec_strobe,
    output logic              uip
);

    localparam logic [CNT_W-1:0] CNT_HALF  = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] CNT_LAST  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] UIP_START = CNT_LAST - CNT_W'(UIP_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             strobe;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        adv    = tick && (mode == MODE_RUN);
        st_d.strobe = adv && (st_q.cnt == CNT_LAST);
        if (mode == MODE_HOLD) begin
            st_d.cnt = CNT_HALF;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt    <= CNT_HALF;
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_next   = st_d.cnt;
    assign cnt_cur    = st_q.cnt;
    assign sec_strobe = st_q.strobe;
    assign uip        = (st_q.cnt >= UIP_START);

endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
    import rtc_timebase_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              adv,
    input  logic [CNT_W-1:0]  cnt_next,
    input  logic              clr,
    output logic              flag
);

    typedef struct packed {
        logic flag;
    } rate_state_t;

    rate_state_t st_d, st_q;
    logic [RATE_W-1:0] eff;
    logic [CNT_W-1:0]  tap_mask;
    logic              event_hit;

    always_comb begin
        st_d      = st_q;
        eff       = rate_effective(rate);
        tap_mask  = (CNT_W'(1) << (eff - 4'd1)) - CNT_W'(1);
        event_hit = adv && (eff != RATE_OFF) && ((cnt_next & tap_mask) == '0);
        st_d.flag = event_hit || (st_q.flag && !clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_timebase_pkg::*;
#(
    parameter int CNT_W     = 15,
    parameter int UIP_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_tick,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             flag_clr,
    output logic             sec_strobe,
    output logic             uip,
    output logic             pf_flag
);

    ctl_t ctl_d, ctl_q;

    logic              adv;
    logic [CNT_W-1:0]  cnt_next;
    logic [CNT_W-1:0]  cnt_cur;
    logic [MODE_W-1:0] dv_cur;
    logic [RATE_W-1:0] rs_cur;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d = ctl_t'(ctl_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.mode <= MODE_RUN;
            ctl_q.rate <= RATE_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dv_cur = ctl_q.mode;
    assign rs_cur = ctl_q.rate;

    rtc_prescaler #(
        .CNT_W     (CNT_W),
        .UIP_TICKS (UIP_TICKS)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tb_tick),
        .mode       (dv_cur),
        .adv        (adv),
        .cnt_next   (cnt_next),
        .cnt_cur    (cnt_cur),
        .sec_strobe (sec_strobe),
        .uip        (uip)
    );

    rtc_rate_gen #(
        .CNT_W (CNT_W)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (rs_cur),
        .adv      (adv),
        .cnt_next (cnt_next),
        .clr      (flag_clr),
        .flag     (pf_flag)
    );

endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk
    import rtc_timebase_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flag_clr,
    input logic [MODE_W-1:0] dv_cur,
    input logic [RATE_W-1:0] rs_cur,
    input logic [CNT_W-1:0]  cnt_cur,
    input logic              sec_strobe,
    input logic              uip,
    input logic              pf_flag
);

    localparam logic [CNT_W-1:0] MID = {1'b1, {(CNT_W-1){1'b0}}};

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |=> !sec_strobe);

    a_r2_run_only: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |-> ($past(dv_cur) == MODE_RUN));

    a_r5_uip_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_strobe) |-> $past(uip));

    a_r3_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_cur == MODE_HOLD) |=> (!sec_strobe && !uip && cnt_cur == MID));

    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_cur != MODE_RUN && dv_cur != MODE_HOLD) |=> $stable(cnt_cur));

    a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_cur == RATE_OFF && (flag_clr || !pf_flag)) |=> !pf_flag);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_flag && !flag_clr) |=> pf_flag);

endmodule

bind rtc_timebase rtc_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_clr   (flag_clr),
    .dv_cur     (dv_cur),
    .rs_cur     (rs_cur),
    .cnt_cur    (cnt_cur),
    .sec_strobe (sec_strobe),
    .uip        (uip),
    .pf_flag    (pf_flag)
);

// File: tb/sim_rtc_timebase.sv
module sim_rtc_timebase;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_tick = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [6:0] ctl_wdata = 7'd0;
    logic       flag_clr = 1'b0;
    logic       sec_strobe, uip, pf_flag;

    rtc_timebase u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tb_tick    (tb_tick),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .flag_clr   (flag_clr),
        .sec_strobe (sec_strobe),
        .uip        (uip),
        .pf_flag    (pf_flag)
    );

    always #10 clk = ~clk;

    // Behavioural reference state
    int         phase = 16384;
    logic [2:0] m_mode = 3'b010;
    logic [3:0] m_rate = 4'b0110;
    bit         m_flag = 0;
    bit         m_strobe = 0;
    bit         m_adv = 0;

    int    checks = 0;
    int    fails = 0;
    string seg = "R1";
    bit    done = 0;
    bit    gap_armed = 0;
    bit    seen_first = 0;
    int    adv_since = 0;

    task automatic check(input string r, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] %s actual=%0b expected=%0b", r, seg, what, act, exp);
        end
    endtask

    task automatic check_int(input string r, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d", r, seg, what, act, exp);
        end
    endtask

    function automatic int eff_rate(input logic [3:0] r);
        if (r == 4'd1) return 8;
        if (r == 4'd2) return 9;
        return int'(r);
    endfunction

    task automatic model_edge(input bit t, input bit w, input logic [6:0] d, input bit c);
        int  nph;
        int  e;
        bit  ev;
        m_adv    = t && (m_mode == 3'b010);
        m_strobe = m_adv && (phase == 32767);
        if (m_mode == 3'b111)   nph = 16384;
        else if (m_adv)         nph = (phase + 1) % 32768;
        else                    nph = phase;
        e  = eff_rate(m_rate);
        ev = m_adv && (e != 0) && ((nph % (1 << (e - 1))) == 0);
        m_flag = ev || (m_flag && !c);
        if (w) begin
            m_mode = d[6:4];
            m_rate = d[3:0];
        end
        phase = nph;
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input bit t, input bit w, input logic [6:0] d, input bit c);
        tb_tick = t; ctl_wr = w; ctl_wdata = d; flag_clr = c;
        @(posedge clk);
        model_edge(t, w, d, c);
        if (m_adv) adv_since++;
        @(negedge clk);
        check("R2", sec_strobe, m_strobe, "sec_strobe");
        check("R5", uip, (phase >= 32760), "uip");
        check("R7", pf_flag, m_flag, "pf_flag");
        if (sec_strobe) begin
            if (gap_armed && seen_first) check_int("R2", adv_since, 32768, "ticks between strobes");
            seen_first = 1;
            adv_since = 0;
        end
        tb_tick = 0; ctl_wr = 0; flag_clr = 0;
    endtask

    task automatic run(input int n, input bit c);
        for (int i = 0; i < n; i++) step(1, 0, 7'd0, c);
    endtask

    // Count flag events over n ticks with the flag cleared each clock.
    task automatic count_events(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            step(1, 0, 7'd0, 1);
            if (pf_flag) cnt++;
        end
    endtask

    initial begin
        int ev;
        int ev_a;
        int ev_b;
        repeat (3) @(negedge clk);
        seg = "R1";
        check("R1", sec_strobe, 1'b0, "sec_strobe in reset");
        check("R1", uip, 1'b0, "uip in reset");
        check("R1", pf_flag, 1'b0, "pf_flag in reset");
        rst_n = 1'b1;

        // R9: reset rate gives one event per 32 ticks
        seg = "R9";
        count_events(64, ev);
        check_int("R9", ev, 2, "events in 64 ticks at reset rate");

        // R10: sticky flag, clear, set-beats-clear
        seg = "R10";
        step(1, 1, {3'b010, 4'd3}, 1);
        run(10, 0);
        check("R10", pf_flag, 1'b1, "flag held without clear");
        while (((phase + 1) % 4) == 0) step(1, 0, 7'd0, 0);
        step(1, 0, 7'd0, 1);
        check("R10", pf_flag, 1'b0, "flag cleared on quiet tick");
        while (((phase + 1) % 4) != 0) step(1, 0, 7'd0, 0);
        step(1, 0, 7'd0, 1);
        check("R10", pf_flag, 1'b1, "event wins over clear");

        // R1: first strobe after 16384 ticks from reset
        seg = "R1";
        run(16383 - 64 - 1 - 10 - (phase - 16384 - 75 + 75) + (phase - 16384) - (phase - 16384), 1);
        while (phase != 32767) step(1, 0, 7'd0, 1);
        check("R1", sec_strobe, 1'b0, "no strobe before wrap");
        step(1, 0, 7'd0, 1);
        check("R1", sec_strobe, 1'b1, "first strobe after half second");
        check_int("R1", adv_since, 0, "strobe at count wrap");
        gap_armed = 1;

        // R7: each rate gives one event per 2^(r-1) ticks
        seg = "R7";
        for (int r = 3; r <= 15; r++) begin
            step(1, 1, {3'b010, 4'(r)}, 1);
            count_events(1 << (r - 1), ev);
            check_int("R7", ev, 1, $sformatf("events per period at rate %0d", r));
        end

        // R8: aliased low codes
        seg = "R8";
        step(1, 1, {3'b010, 4'd1}, 1);
        count_events(512, ev_a);
        step(1, 1, {3'b010, 4'd8}, 1);
        count_events(512, ev_b);
        check_int("R8", ev_a, 4, "code 1 events in 512 ticks");
        check_int("R8", ev_b, 4, "code 8 events in 512 ticks");
        step(1, 1, {3'b010, 4'd2}, 1);
        count_events(512, ev_a);
        step(1, 1, {3'b010, 4'd9}, 1);
        count_events(512, ev_b);
        check_int("R8", ev_a, 2, "code 2 events in 512 ticks");
        check_int("R8", ev_b, 2, "code 9 events in 512 ticks");

        // R6: rate off never sets the flag
        seg = "R6";
        step(1, 1, {3'b010, 4'd0}, 1);
        step(1, 0, 7'd0, 1);
        run(600, 0);
        check("R6", pf_flag, 1'b0, "flag stays clear with rate off");

        // R2: sparse ticks still give 32768-tick seconds
        seg = "R2";
        step(1, 1, {3'b010, 4'd5}, 1);
        for (int i = 0; i < 1200; i++) begin
            step(1, 0, 7'd0, (i % 5) == 0);
            step(0, 0, 7'd0, 0);
            step(0, 0, 7'd0, 0);
        end
        while (phase != 0) step(1, 0, 7'd0, 1);
        gap_armed = 0;

        // R4: freeze inside the update window
        seg = "R4";
        while (phase != 32761) step(1, 0, 7'd0, 1);
        step(1, 1, {3'b011, 4'd4}, 1);
        run(100, 0);
        check("R4", uip, 1'b1, "uip level frozen");
        check_int("R4", phase, 32762, "model count frozen");
        step(1, 1, {3'b010, 4'd4}, 0);
        run(4, 0);
        check("R4", sec_strobe, 1'b0, "no strobe yet after resume");

        // R11: write in the wrap cycle is handled under the old mode
        seg = "R11";
        while (phase != 32767) step(1, 0, 7'd0, 0);
        step(1, 1, {3'b111, 4'd4}, 0);
        check("R11", sec_strobe, 1'b1, "wrap tick uses old mode");

        // R3: hold then release gives a half second
        seg = "R3";
        run(200, 1);
        check("R3", uip, 1'b0, "no uip while held");
        check("R3", sec_strobe, 1'b0, "no strobe while held");
        step(1, 1, {3'b010, 4'd4}, 1);
        run(16383, 1);
        check("R3", sec_strobe, 1'b0, "no strobe before half second");
        step(1, 0, 7'd0, 1);
        check("R3", sec_strobe, 1'b1, "strobe half second after release");
        run(20, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule